// File: doc/BRIEF.md
# Frequency-Based Victim Selection with MRU Shield

This block holds the replacement bookkeeping for a set-associative cache that evicts by usage frequency. Every way of every set keeps a saturating use counter and one protection bit. The protection bit marks the way that was touched or filled most recently, and that way is kept out of eviction. The surrounding cache controller reports one event per cycle. Each event names a set and a way and has one of four kinds: demand hit, demand fill, prefetch fill, or prefetch whose block was already resident. A prefetch fill also carries a flag that selects the insertion policy.

On a separate query side the controller presents a set index, together with the valid bits and stored tags of that set, which it reads from its own tag array. The block returns the way to replace. Invalid ways are chosen first. Among valid ways that are not protected, the lowest use count wins, and equal counts are settled by the smallest tag. The counters and protection bits of the queried set are also driven out, so that the controller can see the state it is steering.

Top module: `lfu_repl_state`

## Requirements
- R1: After synchronous active-low reset, every use counter of every set reads zero and every protection bit reads clear.
- R2: An event of kind 0 (demand hit) adds one to the addressed way's counter, sets that way's protection bit and clears the protection bits of the other ways in the same set.
- R3: A counter at its maximum value (all ones, CNT_W bits) stays at the maximum on a further demand hit instead of wrapping.
- R4: An event of kind 1 (demand fill) loads the way's counter with one, sets its protection bit and clears the others in the set, whatever the policy flag.
- R5: An event of kind 2 (prefetch fill) with the policy flag at 0 loads the counter with zero, sets that way's protection bit and clears the others in the set.
- R6: An event of kind 2 with the policy flag at 1 loads the counter with zero, clears that way's protection bit and leaves the other ways' protection bits unchanged.
- R7: An event of kind 3 (prefetch already present) changes no counter and no protection bit.
- R8: An event changes only the state of the set it names; the other sets keep their counters and protection bits.
- R9: When any way of the queried set is invalid, the victim is the invalid way with the lowest index.
- R10: When all ways are valid, the victim is the way with the lowest counter among the ways whose protection bit is clear.
- R11: Among candidates with equal lowest counters, the way with the numerically smallest tag is chosen; with equal tags as well, the lowest index is chosen.
- R12: With one way per set, that way is the victim even while its protection bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | An event is applied this cycle |
| evt_kind | input | 2 | 0 demand hit, 1 demand fill, 2 prefetch fill, 3 prefetch present |
| evt_set | input | SET_W | Set the event addresses |
| evt_way | input | WAY_W | Way the event addresses |
| evt_lip | input | 1 | Prefetch fill inserts unprotected when 1 |
| qry_set | input | SET_W | Set whose victim and state are reported |
| qry_valid | input | NUM_WAYS | Valid bits of the queried set, bit w for way w |
| qry_tags | input | NUM_WAYS*TAG_W | Tags of the queried set, way w at bits w*TAG_W upward |
| victim_way | output | WAY_W | Way to replace in the queried set |
| obs_cnt | output | NUM_WAYS*CNT_W | Use counters of the queried set, way w at bits w*CNT_W upward |
| obs_mru | output | NUM_WAYS | Protection bits of the queried set |

## Verification
The checks assume that the query inputs are always driven with defined values, and that an event names a set below NUM_SETS and a way below NUM_WAYS. The bench drives every address from bounded loops and from a generator reduced modulo the set and way counts, and it holds the query inputs at defined values from time zero. The victim properties trust the valid bits as given. The sweep therefore covers every valid mask, including the partly filled ones that a real tag array would also present.

// File: rtl/lfu_pkg.sv
`timescale 1ns/1ps
// Shared event encoding for the frequency replacement state.
package lfu_pkg;
    typedef enum logic [1:0] {
        EV_DHIT  = 2'd0,
        EV_DFILL = 2'd1,
        EV_PFILL = 2'd2,
        EV_PPRES = 2'd3
    } lfu_evt_e;
endpackage

// File: rtl/lfu_set_state.sv
`timescale 1ns/1ps
// Per-set counters and protection bits.
// Applies one event when upd_en is high. Assumes upd_way < NUM_WAYS.
module lfu_set_state
    import lfu_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_en,
    input  lfu_evt_e                  upd_kind,
    input  logic [WAY_W-1:0]          upd_way,
    input  logic                      upd_lip,
    output logic [NUM_WAYS*CNT_W-1:0] cnt_o,
    output logic [NUM_WAYS-1:0]       mru_o
);
    localparam logic [CNT_W-1:0]    CNT_MAX = '1;
    localparam logic [CNT_W-1:0]    CNT_ONE = CNT_W'(1);
    localparam logic [NUM_WAYS-1:0] BIT0    = NUM_WAYS'(1);

    logic [CNT_W-1:0]    cnt_q [NUM_WAYS];
    logic [NUM_WAYS-1:0] mru_q;
    logic [NUM_WAYS-1:0] sel_bit;

    // Decode the addressed way into a one-hot mask.
    assign sel_bit = BIT0 << upd_way;

    // Apply the event to the counters and the protection bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WAYS; w++) cnt_q[w] <= '0;
            mru_q <= '0;
        end else if (upd_en) begin
            unique case (upd_kind)
                EV_DHIT: begin
                    mru_q <= sel_bit;
                    if (cnt_q[upd_way] != CNT_MAX)
                        cnt_q[upd_way] <= cnt_q[upd_way] + CNT_ONE;
                end
                EV_DFILL: begin
                    mru_q          <= sel_bit;
                    cnt_q[upd_way] <= CNT_ONE;
                end
                EV_PFILL: begin
                    mru_q          <= upd_lip ? (mru_q & ~sel_bit) : sel_bit;
                    cnt_q[upd_way] <= '0;
                end
                default: ;
            endcase
        end
    end

    // Flatten the counters for the output.
    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_flat
            assign cnt_o[g*CNT_W +: CNT_W] = cnt_q[g];
        end
    endgenerate
    assign mru_o = mru_q;

    // R2
    mru_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mru_q));
    // R2
    hit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_kind == EV_DHIT && cnt_q[upd_way] != CNT_MAX)
        |=> cnt_q[$past(upd_way)] == $past(cnt_q[upd_way]) + CNT_ONE);
    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_kind == EV_DHIT && cnt_q[upd_way] == CNT_MAX)
        |=> cnt_q[$past(upd_way)] == CNT_MAX);
    // R6
    lip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_kind == EV_PFILL && upd_lip)
        |=> (mru_q & ~$past(sel_bit)) == ($past(mru_q) & ~$past(sel_bit)));
    // R7
    ppres_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_kind == EV_PPRES) |=> ($stable(cnt_o) && $stable(mru_q)));
endmodule

// File: rtl/lfu_victim_pick.sv
`timescale 1ns/1ps
// Combinational victim choice for one set.
// Assumes defined valid bits and tags. Invalid ways come first; otherwise the
// lowest count among unprotected ways, with ties settled by smallest tag.
module lfu_victim_pick #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int TAG_W    = 8,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0]       valid_i,
    input  logic [NUM_WAYS*TAG_W-1:0] tags_i,
    input  logic [NUM_WAYS*CNT_W-1:0] cnt_i,
    input  logic [NUM_WAYS-1:0]       mru_i,
    output logic [WAY_W-1:0]          victim_o
);
    logic [WAY_W-1:0]    inv_idx, best_idx;
    logic                have_inv, found;
    logic [NUM_WAYS-1:0] cand;
    logic [CNT_W-1:0]    best_cnt;
    logic [TAG_W-1:0]    best_tag;

    // Scan for an invalid way, then for the least used unprotected way.
    always_comb begin
        have_inv = 1'b0;
        inv_idx  = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                have_inv = 1'b1;
                inv_idx  = WAY_W'(w);
            end
        end
        cand = ~mru_i;
        if (cand == '0) cand = '1;
        found    = 1'b0;
        best_idx = '0;
        best_cnt = '0;
        best_tag = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cand[w] && (!found
                || cnt_i[w*CNT_W +: CNT_W] < best_cnt
                || (cnt_i[w*CNT_W +: CNT_W] == best_cnt
                    && tags_i[w*TAG_W +: TAG_W] < best_tag))) begin
                found    = 1'b1;
                best_idx = WAY_W'(w);
                best_cnt = cnt_i[w*CNT_W +: CNT_W];
                best_tag = tags_i[w*TAG_W +: TAG_W];
            end
        end
        victim_o = have_inv ? inv_idx : best_idx;
    end
endmodule

// File: rtl/lfu_repl_state.sv
`timescale 1ns/1ps
// Top: frequency replacement state for all sets of one cache.
// Routes each event to its set, reports the queried set's state and victim.
// Assumes evt_set < NUM_SETS and evt_way < NUM_WAYS.
module lfu_repl_state
    import lfu_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int TAG_W    = 8,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_valid,
    input  logic [1:0]                evt_kind,
    input  logic [SET_W-1:0]          evt_set,
    input  logic [WAY_W-1:0]          evt_way,
    input  logic                      evt_lip,
    input  logic [SET_W-1:0]          qry_set,
    input  logic [NUM_WAYS-1:0]       qry_valid,
    input  logic [NUM_WAYS*TAG_W-1:0] qry_tags,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS*CNT_W-1:0] obs_cnt,
    output logic [NUM_WAYS-1:0]       obs_mru
);
    logic [NUM_WAYS*CNT_W-1:0] set_cnt [NUM_SETS];
    logic [NUM_WAYS-1:0]       set_mru [NUM_SETS];
    lfu_evt_e                  kind;

    assign kind = lfu_evt_e'(evt_kind);

    // One state slice per set, enabled only by events that name it.
    genvar s;
    generate
        for (s = 0; s < NUM_SETS; s++) begin : g_set
            lfu_set_state #(
                .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)
            ) u_set (
                .clk      (clk),
                .rst_n    (rst_n),
                .upd_en   (evt_valid && (evt_set == SET_W'(s))),
                .upd_kind (kind),
                .upd_way  (evt_way),
                .upd_lip  (evt_lip),
                .cnt_o    (set_cnt[s]),
                .mru_o    (set_mru[s])
            );
        end
    endgenerate

    // Select the queried set's state.
    always_comb begin
        obs_cnt = set_cnt[0];
        obs_mru = set_mru[0];
        for (int i = 0; i < NUM_SETS; i++) begin
            if (qry_set == SET_W'(i)) begin
                obs_cnt = set_cnt[i];
                obs_mru = set_mru[i];
            end
        end
    end

    lfu_victim_pick #(
        .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_pick (
        .valid_i  (qry_valid),
        .tags_i   (qry_tags),
        .cnt_i    (obs_cnt),
        .mru_i    (obs_mru),
        .victim_o (victim_way)
    );

    // R9
    inv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid != '1) |-> !qry_valid[victim_way]);
    // R10
    mru_spared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid == '1 && obs_mru != '1) |-> !obs_mru[victim_way]);
endmodule

// File: tb/lfu_repl_state_tb.sv
`timescale 1ns/1ps
module lfu_repl_state_tb;
    localparam int S = 4, W = 4, CW = 3, TW = 4;
    localparam int CMAX = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic evt_valid = 1'b0, evt_lip = 1'b0;
    logic [1:0] evt_kind = '0, evt_set = '0, evt_way = '0, qry_set = '0;
    logic [W-1:0] qry_valid = '1;
    logic [W*TW-1:0] qry_tags = '0;
    logic [1:0] victim_way;
    logic [W*CW-1:0] obs_cnt;
    logic [W-1:0] obs_mru;

    logic w1_valid = 1'b0, w1_lip = 1'b0, w1_qv = 1'b1;
    logic [1:0] w1_kind = '0;
    logic w1_set = 1'b0, w1_way = 1'b0, w1_qset = 1'b0;
    logic [TW-1:0] w1_tags = '0;
    logic w1_victim;
    logic [CW-1:0] w1_cnt;
    logic w1_mru;

    int checks = 0, fails = 0;
    bit done = 0;
    int ref_cnt [S][W];
    bit ref_mru [S][W];

    always #4 clk = ~clk;

    lfu_repl_state #(.NUM_SETS(S), .NUM_WAYS(W), .CNT_W(CW), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_set(evt_set), .evt_way(evt_way), .evt_lip(evt_lip),
        .qry_set(qry_set), .qry_valid(qry_valid), .qry_tags(qry_tags),
        .victim_way(victim_way), .obs_cnt(obs_cnt), .obs_mru(obs_mru));

    lfu_repl_state #(.NUM_SETS(2), .NUM_WAYS(1), .CNT_W(CW), .TAG_W(TW)) u_dut_w1 (
        .clk(clk), .rst_n(rst_n), .evt_valid(w1_valid), .evt_kind(w1_kind),
        .evt_set(w1_set), .evt_way(w1_way), .evt_lip(w1_lip),
        .qry_set(w1_qset), .qry_valid(w1_qv), .qry_tags(w1_tags),
        .victim_way(w1_victim), .obs_cnt(w1_cnt), .obs_mru(w1_mru));

    // Compare the queried state of every set with the model.
    task automatic check_all(int ev_set, string req);
        for (int s = 0; s < S; s++) begin
            logic [W*CW-1:0] ec;
            logic [W-1:0] em;
            qry_set = s[1:0];
            #0.2;
            for (int w = 0; w < W; w++) begin
                ec[w*CW +: CW] = ref_cnt[s][w][CW-1:0];
                em[w] = ref_mru[s][w];
            end
            checks++;
            if (obs_cnt !== ec || obs_mru !== em) begin
                fails++;
                $display("FAIL %s set=%0d cnt=%h/%h mru=%b/%b (actual/expected)",
                         (s == ev_set) ? req : "R8", s, obs_cnt, ec, obs_mru, em);
            end
        end
    endtask

    // Apply one event and advance the model from the requirements.
    task automatic apply_ev(int kind, int s, int w, bit lip, string req);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = kind[1:0]; evt_set = s[1:0];
        evt_way = w[1:0]; evt_lip = lip;
        @(negedge clk);
        evt_valid = 1'b0;
        case (kind)
            0: begin
                for (int i = 0; i < W; i++) ref_mru[s][i] = (i == w);
                if (ref_cnt[s][w] < CMAX) ref_cnt[s][w]++;
            end
            1: begin
                for (int i = 0; i < W; i++) ref_mru[s][i] = (i == w);
                ref_cnt[s][w] = 1;
            end
            2: begin
                if (lip) ref_mru[s][w] = 0;
                else for (int i = 0; i < W; i++) ref_mru[s][i] = (i == w);
                ref_cnt[s][w] = 0;
            end
            default: ;
        endcase
        check_all(s, req);
    endtask

    // Expected victim from the model state and the query inputs.
    function automatic int exp_victim(int s, logic [W-1:0] v, logic [W*TW-1:0] t,
                                      output string req);
        int best = -1, bc = 0, bt = 0, ties = 0;
        bit cand [W];
        bit any = 0;
        for (int w = 0; w < W; w++) if (!v[w]) begin req = "R9"; return w; end
        for (int w = 0; w < W; w++) begin cand[w] = !ref_mru[s][w]; any |= cand[w]; end
        if (!any) for (int w = 0; w < W; w++) cand[w] = 1;
        for (int w = 0; w < W; w++) begin
            int c = ref_cnt[s][w];
            int tg = int'(t[w*TW +: TW]);
            if (!cand[w]) continue;
            if (best < 0 || c < bc) begin best = w; bc = c; bt = tg; ties = 0; end
            else if (c == bc) begin
                ties++;
                if (tg < bt) begin best = w; bt = tg; end
            end
        end
        req = (ties > 0) ? "R11" : "R10";
        return best;
    endfunction

    task automatic check_victim(int s, logic [W-1:0] v, logic [W*TW-1:0] t);
        string req;
        int e;
        qry_set = s[1:0]; qry_valid = v; qry_tags = t;
        #0.2;
        e = exp_victim(s, v, t, req);
        checks++;
        if (int'(victim_way) != e) begin
            fails++;
            $display("FAIL %s set=%0d valid=%b victim=%0d expected=%0d",
                     req, s, v, victim_way, e);
        end
    endtask

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) begin ref_cnt[s][w] = 0; ref_mru[s][w] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all(-1, "R1");
        // R4: fill every way of every set on demand
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) apply_ev(1, s, w, w[0], "R4");
        // R2 and R3: repeated hits on one way run into saturation
        for (int i = 0; i < 9; i++) apply_ev(0, 0, 2, 1'b0, (i < 6) ? "R2" : "R3");
        apply_ev(0, 0, 1, 1'b0, "R2");
        // R5, R6, R7 on set 1
        apply_ev(2, 1, 3, 1'b0, "R5");
        apply_ev(0, 1, 1, 1'b0, "R2");
        apply_ev(2, 1, 0, 1'b1, "R6");
        apply_ev(2, 1, 1, 1'b1, "R6");
        apply_ev(3, 1, 2, 1'b0, "R7");
        apply_ev(3, 1, 3, 1'b1, "R7");
        // R11: set 3 ways 1..3 at count 1, way 0 protected; tags 0,5,2,2 -> way 2
        apply_ev(0, 3, 0, 1'b0, "R2");
        qry_set = 2'd3; qry_valid = '1; qry_tags = {4'd2, 4'd2, 4'd5, 4'd0};
        #0.2;
        checks++;
        if (victim_way !== 2'd2) begin
            fails++;
            $display("FAIL R11 victim=%0d expected=2", victim_way);
        end
        // Pseudo-random event stream against the model
        for (int i = 0; i < 400; i++) begin
            int k, s, w;
            bit l;
            string rq;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            k = int'(lcg[17:16]); s = int'(lcg[21:20]); w = int'(lcg[25:24]);
            l = lcg[28];
            rq = (k == 0) ? "R2" : (k == 1) ? "R4" : (k == 3) ? "R7" : (l ? "R6" : "R5");
            apply_ev(k, s, w, l, rq);
            if (i % 100 == 99)
                for (int v = 0; v < 16; v++)
                    for (int p = 0; p < 4; p++) begin
                        logic [W*TW-1:0] t;
                        for (int w2 = 0; w2 < W; w2++)
                            t[w2*TW +: TW] = (p == 3) ? 4'd7 : TW'((w2 * 5 + p * 3 + s) % 4);
                        check_victim(s, v[W-1:0], t);
                    end
        end
        // R9, R10, R11: sweep every valid mask and tag pattern on every set
        for (int s = 0; s < S; s++)
            for (int v = 0; v < 16; v++)
                for (int p = 0; p < 4; p++) begin
                    logic [W*TW-1:0] t;
                    for (int w = 0; w < W; w++)
                        t[w*TW +: TW] = (p == 3) ? 4'd7 : TW'((w * 5 + p * 3 + s) % 4);
                    check_victim(s, v[W-1:0], t);
                end
        // R12: one-way sets evict their only way even while protected
        @(negedge clk);
        w1_valid = 1'b1; w1_kind = 2'd1; w1_set = 1'b1; w1_way = 1'b0;
        @(negedge clk);
        w1_valid = 1'b0; w1_qset = 1'b1; w1_qv = 1'b1;
        #0.2;
        checks++;
        if (w1_mru !== 1'b1 || w1_victim !== 1'b0) begin
            fails++;
            $display("FAIL R12 mru=%b victim=%0d expected mru=1 victim=0", w1_mru, w1_victim);
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule